// File: doc/BRIEF.md
# Dual-Modulus Programmable Prescaler

This block divides a fast input clock by P or by P+1. The modulus line chooses between the two ratios for each divide period. A mode bit chooses the ratio pair: 8/9 when the bit is 0 and 32/33 when the bit is 1. The divider is built from a synchronous core that divides by 4 or by 5, followed by a chain of toggle stages. The chain has one stage for the 8/9 pair and three stages for the 32/33 pair. When P+1 is requested, the core divides by 5 in the first core cycle of the period and by 4 in every other core cycle.

Both the modulus line and the mode bit are sampled only on the clock edge that ends a divide period. The sampled values govern the next period, so a period is never a mix of two ratios. At the end of each period the block produces one pulse on its output, one fast clock wide. A downstream swallow counter or main counter can use this pulse as its clock enable.

Top module: `dual_mod_prescaler`

## Requirements
- R1: With the mode bit at 0 and the modulus line at 0 in effect, rising edges of div_pulse are exactly 8 clocks apart.
- R2: With the mode bit at 0 and the modulus line at 1 in effect, rising edges of div_pulse are exactly 9 clocks apart.
- R3: With the mode bit at 1 and the modulus line at 1 in effect, consecutive pulses are exactly 33 clocks apart.
- R4: With the mode bit at 1 and the modulus line at 0 in effect, consecutive pulses are exactly 32 clocks apart.
- R5: mod_ctl is sampled only on the clock edge on which div_pulse rises, and it sets the ratio of the period that starts at that edge. Changes of mod_ctl at any other time have no effect.
- R6: mode_sel is sampled on that same edge with the same rule. A change of mode_sel in the middle of a period does not alter the period that follows.
- R7: div_pulse is high for exactly one clock and is low in the clock that follows.
- R8: While rst_n is low, div_pulse is low. After release, the first pulse comes exactly 8 clocks later, whatever mode_sel and mod_ctl are.
- R9: Each period is made of core cycles of 4 clocks, with at most one 5-clock core cycle. That 5-clock cycle occurs only when P+1 is in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 1 | Ratio pair: 0 selects 8/9, 1 selects 32/33 |
| mod_ctl | input | 1 | Modulus request: 0 selects P, 1 selects P+1 |
| div_pulse | output | 1 | One-clock pulse at the end of each divide period |

## Verification
div_pulse rises on the clock edge that ends a period. The mode and modulus values present on that same edge apply to the period that starts there. The bench therefore drives its inputs at falling edges, times each period from one pulse sample to the next, and expects the length set by the values that were present at the previous pulse. It also changes the inputs in the middle of a period and then restores them. In a separate test it holds mod_ctl high for a single clock that ends exactly on the boundary edge. These two tests show that only the boundary sample counts. The single-clock width of the pulse is checked at the falling edge after each pulse.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
  // Low modulus of the core and its counter width
  localparam int CORE_LO     = 4;
  localparam int CORE_CNT_W  = 3;
  // Toggle stages after the core for each ratio pair
  localparam int STAGES_SMALL = 1;
  localparam int STAGES_LARGE = 3;

  // Divide ratio for a given pair and modulus request
  function automatic int unsigned pair_ratio(input logic mode, input logic plus1);
    int unsigned stages;
    stages = mode ? STAGES_LARGE : STAGES_SMALL;
    return (CORE_LO << stages) + (plus1 ? 1 : 0);
  endfunction
endpackage

// File: rtl/dmp_core45.sv
module dmp_core45 #(
  parameter int CNT_W   = dmp_pkg::CORE_CNT_W,
  parameter int LOW_DIV = dmp_pkg::CORE_LO
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             five_en,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  localparam logic [CNT_W-1:0] LAST_LO = CNT_W'(LOW_DIV - 1);
  localparam logic [CNT_W-1:0] LAST_HI = CNT_W'(LOW_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_val;

  assign last_val = five_en ? LAST_HI : LAST_LO;
  assign wrap     = (cnt_q == last_val);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dmp_toggle_chain.sv
module dmp_toggle_chain #(
  parameter int STAGES = dmp_pkg::STAGES_LARGE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              clr,
  output logic [STAGES-1:0] q
);
  logic [STAGES:0] carry;
  assign carry[0] = adv;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic t_q;
    assign carry[i+1] = carry[i] & t_q;
    assign q[i]       = t_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        t_q <= 1'b0;
      else if (clr)      t_q <= 1'b0;
      else if (carry[i]) t_q <= ~t_q;
    end
  end
endmodule

// File: rtl/dual_mod_prescaler.sv
module dual_mod_prescaler #(
  parameter int CNT_W      = dmp_pkg::CORE_CNT_W,
  parameter int STG_SMALL  = dmp_pkg::STAGES_SMALL,
  parameter int STG_LARGE  = dmp_pkg::STAGES_LARGE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic mod_ctl,
  output logic div_pulse
);
  // Values latched at each period boundary
  logic mode_lat;
  logic mod_lat;

  // Named internal events
  logic [CNT_W-1:0]     core_cnt;
  logic                 core_wrap;
  logic                 five_en;
  logic [STG_LARGE-1:0] ext_q;
  logic                 ext_first;
  logic                 last_step;
  logic                 period_end;
  logic                 pulse_q;

  assign ext_first  = (ext_q == '0);
  assign five_en    = mod_lat & ext_first;
  assign last_step  = mode_lat ? (&ext_q[STG_LARGE-1:0]) : (&ext_q[STG_SMALL-1:0]);
  assign period_end = core_wrap & last_step;

  dmp_core45 #(.CNT_W(CNT_W)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .five_en (five_en),
    .cnt     (core_cnt),
    .wrap    (core_wrap)
  );

  dmp_toggle_chain #(.STAGES(STG_LARGE)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (core_wrap),
    .clr   (period_end),
    .q     (ext_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_lat <= 1'b0;
      mod_lat  <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      pulse_q <= period_end;
      if (period_end) begin
        mode_lat <= mode_sel;
        mod_lat  <= mod_ctl;
      end
    end
  end

  assign div_pulse = pulse_q;
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
  parameter int CNT_W = dmp_pkg::CORE_CNT_W,
  parameter int GAP_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             div_pulse,
  input logic             period_end,
  input logic             mode_lat,
  input logic             mod_lat,
  input logic [CNT_W-1:0] core_cnt,
  input logic             core_wrap
);
  localparam logic [CNT_W-1:0] FIVE_LAST = CNT_W'(dmp_pkg::CORE_LO);

  logic [GAP_W-1:0] gap_q;
  logic [GAP_W-1:0] len_q;
  logic             fives_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q   <= '0;
      len_q   <= GAP_W'(dmp_pkg::pair_ratio(1'b0, 1'b0));
      fives_q <= 1'b0;
    end else begin
      if (div_pulse) begin
        gap_q <= GAP_W'(1);
        len_q <= GAP_W'(dmp_pkg::pair_ratio(mode_lat, mod_lat));
      end else begin
        gap_q <= gap_q + 1'b1;
      end
      if (period_end)                            fives_q <= 1'b0;
      else if (core_wrap && core_cnt == FIVE_LAST) fives_q <= 1'b1;
    end
  end

  // R1 R2 R3 R4 R8: pulse spacing matches the latched ratio
  p_period_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> gap_q == len_q);

  p_pulse_one_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  p_mod_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(mod_lat));

  p_mode_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !period_end |=> $stable(mode_lat));

  p_single_swallow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wrap && core_cnt == FIVE_LAST) |-> (!fives_q && mod_lat));

  p_core_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_cnt <= FIVE_LAST);
endmodule

bind dual_mod_prescaler dmp_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .div_pulse  (div_pulse),
  .period_end (period_end),
  .mode_lat   (mode_lat),
  .mod_lat    (mod_lat),
  .core_cnt   (core_cnt),
  .core_wrap  (core_wrap)
);

// File: tb/tb_dual_mod_prescaler.sv
module tb_dual_mod_prescaler;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b0;
  logic mod_ctl = 1'b0;
  logic div_pulse;

  int checks = 0;
  int errors = 0;
  int exp_cur = 8;

  always #5 clk = ~clk;

  dual_mod_prescaler dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_sel  (mode_sel),
    .mod_ctl   (mod_ctl),
    .div_pulse (div_pulse)
  );

  function automatic int want_len(input logic big, input logic extra);
    int base;
    base = big ? 32 : 8;
    return extra ? base + 1 : base;
  endfunction

  function automatic string tag_for(input int len);
    case (len)
      8:       return "R1/R9";
      9:       return "R2/R9";
      33:      return "R3/R9";
      default: return "R4/R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Count falling edges until a pulse is seen; start is the count already elapsed
  task automatic measure(input int start, input int exp, input string tag);
    int  n = start;
    bit  seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      n++;
      if (div_pulse) seen = 1'b1;
    end
    check(seen && n == exp, tag, n, exp);
  endtask

  task automatic do_reset(input logic m, input logic c);
    rst_n = 1'b0; mode_sel = m; mod_ctl = c;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(div_pulse == 1'b0, "R8 reset low", int'(div_pulse), 0);
    end
    rst_n = 1'b1;
    measure(0, 8, "R8 first period");
    exp_cur = want_len(m, c);
  endtask

  task automatic run_period(input logic m, input logic c);
    mode_sel = m; mod_ctl = c;
    measure(0, exp_cur, tag_for(exp_cur));
    exp_cur = want_len(m, c);
  endtask

  task automatic pulse_width();
    @(negedge clk);
    check(div_pulse == 1'b0, "R7 pulse width", int'(div_pulse), 0);
    measure(1, exp_cur, tag_for(exp_cur));
    exp_cur = want_len(mode_sel, mod_ctl);
  endtask

  // Mid-period changes that are undone before the boundary
  task automatic mid_glitch();
    int n = 0;
    mode_sel = 1'b0; mod_ctl = 1'b0;
    for (int i = 0; i < 2; i++) begin @(negedge clk); n++; end
    mode_sel = 1'b1; mod_ctl = 1'b1;
    for (int i = 0; i < 3; i++) begin @(negedge clk); n++; end
    mode_sel = 1'b0; mod_ctl = 1'b0;
    measure(n, exp_cur, "R5/R6 glitch period");
    exp_cur = 8;
    measure(0, 8, "R5/R6 glitch ignored");
  endtask

  // mod_ctl high only for the one clock that ends on the boundary edge
  task automatic boundary_hit();
    int n = 0;
    mode_sel = 1'b0; mod_ctl = 1'b0;
    for (int i = 0; i < 7; i++) begin @(negedge clk); n++; end
    mod_ctl = 1'b1;
    @(negedge clk); n++;
    mod_ctl = 1'b0;
    check(div_pulse == 1'b1 && n == 8, "R5 boundary period", n, 8);
    measure(0, 9, "R5 boundary sample");
    exp_cur = 8;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1, 1'b1);   // next period 33
    run_period(0, 0);       // measures 33
    run_period(0, 1);       // measures 8
    run_period(1, 0);       // measures 9
    run_period(1, 1);       // measures 32
    run_period(0, 1);       // measures 33
    pulse_width();          // measures 9, R7
    run_period(0, 0);       // measures 9
    run_period(0, 0);       // measures 8
    mid_glitch();
    boundary_hit();
    run_period(1, 0);       // measures 8
    pulse_width();          // measures 32, R7
    do_reset(1'b0, 1'b1);
    run_period(0, 0);       // measures 9
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule